// File: doc/BRIEF.md
# Boundary-Scan Pin Activity Monitor

This block is a JTAG host that watches every boundary-scan cell of a target device without disturbing it. It generates TCK, TMS and TDI, reads TDO, resets the target's TAP controller, loads a non-intrusive sampling instruction, and then keeps taking snapshots. Each snapshot is a Capture-DR of all pin states followed by shifting the whole boundary register out. The target's pins keep doing their normal work, because the loaded instruction only samples them and never drives them.

Every completed snapshot is compared with the one before it. Each bit position is classified as steady low, steady high or toggling, with toggle history kept over a programmable window of snapshots. Software or a display engine reads the class of any bit through a combinational read port, and a one-cycle ready pulse marks each new snapshot. The chain length is programmable up to `MAX_BITS`, which defaults to 512.

Top module: `jtag_pin_monitor`

## Requirements
- R1: While reset is asserted and afterwards until `run` rises: `tck` = 0, `tms` = 1, `snap_ready` = 0, and `rd_stat` reads 2'b11 for every address.
- R2: While monitoring, `tck` toggles on every `clk` edge, so one TCK period is two `clk` cycles. `tms` and `tdi` change only on the `clk` edge on which `tck` falls.
- R3: After `run` rises, the first 5 TCK rising edges carry `tms` = 1. The sampling instruction `SAMPLE_CODE` is then shifted in LSB first through the IR path, and only after that does any Capture-DR occur.
- R4: Each snapshot is one Capture-DR followed by exactly `chain_len` Shift-DR clocks. TDO is sampled on each TCK rising edge, and the k-th shifted bit (starting at 0) is stored as bit position k.
- R5: While `run` stays high, snapshots repeat back to back through Update-DR and Select-DR, with no Run-Test/Idle between them. `snap_ready` pulses high for exactly one `clk` cycle after each snapshot is stored.
- R6: The `rd_stat` encoding for a bit is: 2'b00 steady low, 2'b01 steady high, 2'b10 toggling, 2'b11 no snapshot since the last start.
- R7: Snapshots are grouped into windows of `win_len` snapshots (0 acts as 1). A bit reads toggling if it changed between any consecutive pair of snapshots whose later member lies in the current window, up to the latest snapshot. The flag clears at each window's first snapshot, which is still compared with the one before it.
- R8: The first snapshot after a start never reports toggling. Its bits read as their captured level.
- R9: After `run` falls, at most one further snapshot completes. Then `tck` stays low and `rd_stat` stays unchanged.
- R10: Chain lengths from 1 to `MAX_BITS` work, including a 420-bit chain.
- R11: For a fixed `rd_addr`, `rd_stat` changes only in the cycle of a `snap_ready` pulse or in the cycle right after a start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; TCK runs at half this rate |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | High to monitor; a rise starts a full TAP reset and instruction load |
| chain_len | input | LEN_W | Boundary register length in bits (held stable while running) |
| win_len | input | WIN_W | Toggle window length in snapshots |
| tdo | input | 1 | Test data from the target |
| tck | output | 1 | Test clock to the target |
| tms | output | 1 | Test mode select to the target |
| tdi | output | 1 | Test data to the target |
| rd_addr | input | LEN_W | Bit position to read |
| rd_stat | output | 2 | Class of the addressed bit (R6 encoding) |
| snap_ready | output | 1 | One-cycle pulse after each stored snapshot |

## Verification
The bench models a target TAP whose pins follow arithmetic patterns: constant low, constant high, flipping every snapshot, and flipping every fourth snapshot. Window lengths that straddle those periods expose a design that fails to clear the toggle flag at a window boundary, or that clears it without comparing the window's first snapshot to its predecessor. Such a design reports the slow bits wrongly in alternate windows. A one-bit chain and a 420-bit chain catch off-by-one shift counts, which would put every bit one position off or leave the TAP in Shift-DR. Restart and stop sequences catch a missing TAP reset, a wrong instruction code, status that survives a restart, and TCK that keeps running after `run` falls.

// File: rtl/jtag_pm_pkg.sv
package jtag_pm_pkg;

    typedef enum logic [3:0] {
        TAP_TLR, TAP_RTI, TAP_SELDR, TAP_CAPDR, TAP_SHDR, TAP_EX1DR, TAP_PAUDR, TAP_EX2DR,
        TAP_UPDR, TAP_SELIR, TAP_CAPIR, TAP_SHIR, TAP_EX1IR, TAP_PAUIR, TAP_EX2IR, TAP_UPIR
    } tap_e;

    typedef enum logic [1:0] {
        PST_LOW  = 2'b00,
        PST_HIGH = 2'b01,
        PST_TOG  = 2'b10,
        PST_NONE = 2'b11
    } pin_stat_e;

    // Standard TAP transition as seen by the host, driven by the TMS level at a TCK rise
    function automatic tap_e tap_step(tap_e s, logic m);
        case (s)
            TAP_TLR:   return m ? TAP_TLR   : TAP_RTI;
            TAP_RTI:   return m ? TAP_SELDR : TAP_RTI;
            TAP_SELDR: return m ? TAP_SELIR : TAP_CAPDR;
            TAP_CAPDR: return m ? TAP_EX1DR : TAP_SHDR;
            TAP_SHDR:  return m ? TAP_EX1DR : TAP_SHDR;
            TAP_EX1DR: return m ? TAP_UPDR  : TAP_PAUDR;
            TAP_PAUDR: return m ? TAP_EX2DR : TAP_PAUDR;
            TAP_EX2DR: return m ? TAP_UPDR  : TAP_SHDR;
            TAP_UPDR:  return m ? TAP_SELDR : TAP_RTI;
            TAP_SELIR: return m ? TAP_TLR   : TAP_CAPIR;
            TAP_CAPIR: return m ? TAP_EX1IR : TAP_SHIR;
            TAP_SHIR:  return m ? TAP_EX1IR : TAP_SHIR;
            TAP_EX1IR: return m ? TAP_UPIR  : TAP_PAUIR;
            TAP_PAUIR: return m ? TAP_EX2IR : TAP_PAUIR;
            TAP_EX2IR: return m ? TAP_UPIR  : TAP_SHIR;
            default:   return m ? TAP_SELDR : TAP_RTI;
        endcase
    endfunction

endpackage

// File: rtl/jtag_pm_seq.sv
module jtag_pm_seq
    import jtag_pm_pkg::*;
#(
    parameter int LEN_W = 10,
    parameter int IR_LEN = 8,
    parameter logic [IR_LEN-1:0] SAMPLE_CODE = 'h02,
    parameter int RST_TCKS = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [LEN_W-1:0] chain_len,
    input  logic             tdo,
    output logic             tck,
    output logic             tms,
    output logic             tdi,
    output logic             start,
    output logic             bit_vld,
    output logic [LEN_W-1:0] bit_idx,
    output logic             bit_val,
    output logic             snap_done
);
    localparam int IRC_W = $clog2(IR_LEN + RST_TCKS + 1);
    localparam int CNT_W = (LEN_W > IRC_W) ? LEN_W : IRC_W;

    typedef struct packed {
        logic             act;
        tap_e             tap;
        logic [CNT_W-1:0] cnt;
        logic             ir_ok;
        logic             tck;
        logic             tms;
        logic             tdi;
        logic             start;
        logic             bvld;
        logic [LEN_W-1:0] bidx;
        logic             bval;
        logic             done;
    } seq_t;

    seq_t q, d;
    logic [CNT_W-1:0]  len_m1;
    logic [IR_LEN-1:0] ir_rest;

    assign len_m1  = (chain_len == '0) ? '0 : CNT_W'(chain_len) - 1'b1;
    assign ir_rest = SAMPLE_CODE >> q.cnt;

    always_comb begin
        d       = q;
        d.start = 1'b0;
        d.bvld  = 1'b0;
        d.done  = 1'b0;
        if (!q.act) begin
            d.tck = 1'b0;
            if (run) begin
                d.act   = 1'b1;
                d.tap   = TAP_TLR;
                d.cnt   = '0;
                d.ir_ok = 1'b0;
                d.tms   = 1'b1;
                d.start = 1'b1;
            end
        end else if (!q.tck) begin
            // rising TCK: target samples TMS/TDI, host samples TDO
            d.tck = 1'b1;
            if (q.tap == TAP_SHDR) begin
                d.bvld = 1'b1;
                d.bidx = q.cnt[LEN_W-1:0];
                d.bval = tdo;
            end
            if (q.tap == TAP_EX1DR) d.done  = 1'b1;
            if (q.tap == TAP_UPIR)  d.ir_ok = 1'b1;
            d.tap = tap_step(q.tap, q.tms);
            d.cnt = (d.tap == q.tap) ? q.cnt + 1'b1 : '0;
        end else begin
            // falling TCK: present next TMS/TDI
            d.tck = 1'b0;
            d.tdi = 1'b0;
            case (q.tap)
                TAP_TLR:   d.tms = (q.cnt < CNT_W'(RST_TCKS));
                TAP_RTI: begin
                    d.tms = 1'b1;
                    d.act = run;
                end
                TAP_SELDR: d.tms = !q.ir_ok;
                TAP_SELIR: d.tms = 1'b0;
                TAP_CAPIR: d.tms = 1'b0;
                TAP_SHIR: begin
                    d.tdi = ir_rest[0];
                    d.tms = (q.cnt == CNT_W'(IR_LEN - 1));
                end
                TAP_EX1IR: d.tms = 1'b1;
                TAP_UPIR:  d.tms = 1'b0;
                TAP_CAPDR: d.tms = 1'b0;
                TAP_SHDR:  d.tms = (q.cnt == len_m1);
                TAP_EX1DR: d.tms = 1'b1;
                TAP_UPDR:  d.tms = run;
                default:   d.tms = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.tap   <= TAP_TLR;
            q.tms   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign tck       = q.tck;
    assign tms       = q.tms;
    assign tdi       = q.tdi;
    assign start     = q.start;
    assign bit_vld   = q.bvld;
    assign bit_idx   = q.bidx;
    assign bit_val   = q.bval;
    assign snap_done = q.done;

endmodule

// File: rtl/jtag_pm_hist.sv
module jtag_pm_hist
    import jtag_pm_pkg::*;
#(
    parameter int MAX_BITS = 512,
    parameter int LEN_W = 10,
    parameter int WIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             bit_vld,
    input  logic [LEN_W-1:0] bit_idx,
    input  logic             bit_val,
    input  logic             snap_done,
    input  logic [WIN_W-1:0] win_len,
    input  logic [LEN_W-1:0] rd_addr,
    output logic [1:0]       rd_stat,
    output logic             ready
);
    typedef struct packed {
        logic [MAX_BITS-1:0] stage;
        logic [MAX_BITS-1:0] last;
        logic [MAX_BITS-1:0] tog;
        logic                valid;
        logic [WIN_W-1:0]    wcnt;
        logic                ready;
    } hist_t;

    hist_t q, d;
    logic [WIN_W:0] wnext;

    assign wnext = {1'b0, q.wcnt} + 1'b1;

    always_comb begin
        d       = q;
        d.ready = 1'b0;
        if (start) begin
            d.valid = 1'b0;
            d.wcnt  = '0;
        end
        if (bit_vld && (int'(bit_idx) < MAX_BITS)) d.stage[bit_idx] = bit_val;
        if (snap_done) begin
            d.last  = q.stage;
            d.tog   = ((q.wcnt == '0) ? '0 : q.tog) | (q.valid ? (q.stage ^ q.last) : '0);
            d.valid = 1'b1;
            d.wcnt  = (wnext >= {1'b0, win_len}) ? '0 : wnext[WIN_W-1:0];
            d.ready = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        if (!q.valid || int'(rd_addr) >= MAX_BITS) rd_stat = PST_NONE;
        else if (q.tog[rd_addr])                   rd_stat = PST_TOG;
        else                                       rd_stat = {1'b0, q.last[rd_addr]};
    end

    assign ready = q.ready;

endmodule

// File: rtl/jtag_pin_monitor.sv
module jtag_pin_monitor
    import jtag_pm_pkg::*;
#(
    parameter int MAX_BITS = 512,
    parameter int WIN_W = 8,
    parameter int IR_LEN = 8,
    parameter logic [IR_LEN-1:0] SAMPLE_CODE = 'h02,
    localparam int LEN_W = $clog2(MAX_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [LEN_W-1:0] chain_len,
    input  logic [WIN_W-1:0] win_len,
    input  logic             tdo,
    output logic             tck,
    output logic             tms,
    output logic             tdi,
    input  logic [LEN_W-1:0] rd_addr,
    output logic [1:0]       rd_stat,
    output logic             snap_ready
);
    logic             seq_start;
    logic             bvld;
    logic [LEN_W-1:0] bidx;
    logic             bval;
    logic             sdone;

    jtag_pm_seq #(
        .LEN_W(LEN_W), .IR_LEN(IR_LEN), .SAMPLE_CODE(SAMPLE_CODE), .RST_TCKS(5)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .run(run), .chain_len(chain_len), .tdo(tdo),
        .tck(tck), .tms(tms), .tdi(tdi), .start(seq_start),
        .bit_vld(bvld), .bit_idx(bidx), .bit_val(bval), .snap_done(sdone)
    );

    jtag_pm_hist #(
        .MAX_BITS(MAX_BITS), .LEN_W(LEN_W), .WIN_W(WIN_W)
    ) u_hist (
        .clk(clk), .rst_n(rst_n), .start(seq_start),
        .bit_vld(bvld), .bit_idx(bidx), .bit_val(bval), .snap_done(sdone),
        .win_len(win_len), .rd_addr(rd_addr), .rd_stat(rd_stat), .ready(snap_ready)
    );

endmodule

// File: rtl/jtag_pm_chk.sv
module jtag_pm_chk #(
    parameter int LEN_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tck,
    input logic             tms,
    input logic             tdi,
    input logic             snap_ready,
    input logic [LEN_W-1:0] chain_len,
    input logic [LEN_W-1:0] rd_addr,
    input logic [1:0]       rd_stat,
    input logic             start,
    input logic             bit_vld,
    input logic             snap_done
);
    logic [2:0]       rise_cnt;
    logic [LEN_W-1:0] nbits;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_cnt <= '0;
            nbits    <= '0;
        end else begin
            if (start)                         rise_cnt <= '0;
            else if (tck && rise_cnt < 3'd5)   rise_cnt <= rise_cnt + 1'b1;
            if (start || snap_done)            nbits <= '0;
            else if (bit_vld)                  nbits <= nbits + 1'b1;
        end
    end

    // R2
    pins_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($changed(tms) || $changed(tdi)) |-> $past(tck));

    // R2
    tck_half_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tck) |=> $fell(tck));

    // R3
    reset_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tck) && rise_cnt < 3'd5) |-> tms);

    // R4
    shift_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_done && chain_len != '0) |-> (nbits == chain_len));

    // R5
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snap_ready |=> !snap_ready);

    // R11
    stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($changed(rd_stat) && $stable(rd_addr)) |-> (snap_ready || $past(start)));

endmodule

bind jtag_pin_monitor jtag_pm_chk #(.LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tck(tck), .tms(tms), .tdi(tdi),
    .snap_ready(snap_ready), .chain_len(chain_len), .rd_addr(rd_addr), .rd_stat(rd_stat),
    .start(seq_start), .bit_vld(bvld), .snap_done(sdone)
);

// File: tb/sim_jtag_pin_monitor.sv
`timescale 1ns/1ps
module sim_jtag_pin_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int MAXB = 512;
    localparam int LW = $clog2(MAXB + 1);
    localparam int WW = 8;
    localparam int TGT = 420;
    localparam logic [7:0] CODE = 8'h02;

    logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, tdo = 1'b0;
    logic [LW-1:0] chain_len = '0, rd_addr = '0;
    logic [WW-1:0] win_len = '0;
    logic tck, tms, tdi, snap_ready;
    logic [1:0] rd_stat;

    int checks = 0, errs = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    jtag_pin_monitor #(.MAX_BITS(MAXB), .WIN_W(WW), .IR_LEN(8), .SAMPLE_CODE(CODE)) u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .chain_len(chain_len), .win_len(win_len),
        .tdo(tdo), .tck(tck), .tms(tms), .tdi(tdi), .rd_addr(rd_addr),
        .rd_stat(rd_stat), .snap_ready(snap_ready)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // ---------------- target TAP model ----------------
    localparam int T_TLR=0, T_RTI=1, T_SDR=2, T_CDR=3, T_SHD=4, T_E1D=5, T_PDR=6, T_E2D=7,
                   T_UDR=8, T_SIR=9, T_CIR=10, T_SHI=11, T_E1I=12, T_PIR=13, T_E2I=14, T_UIR=15;

    function automatic int nxt(int s, logic m);
        case (s)
            T_TLR: return m ? T_TLR : T_RTI;
            T_RTI: return m ? T_SDR : T_RTI;
            T_SDR: return m ? T_SIR : T_CDR;
            T_CDR: return m ? T_E1D : T_SHD;
            T_SHD: return m ? T_E1D : T_SHD;
            T_E1D: return m ? T_UDR : T_PDR;
            T_PDR: return m ? T_E2D : T_PDR;
            T_E2D: return m ? T_UDR : T_SHD;
            T_UDR: return m ? T_SDR : T_RTI;
            T_SIR: return m ? T_TLR : T_CIR;
            T_CIR: return m ? T_E1I : T_SHI;
            T_SHI: return m ? T_E1I : T_SHI;
            T_E1I: return m ? T_UIR : T_PIR;
            T_PIR: return m ? T_E2I : T_PIR;
            T_E2I: return m ? T_UIR : T_SHI;
            default: return m ? T_SDR : T_RTI;
        endcase
    endfunction

    function automatic logic pinv(int i, int k);
        case (i % 4)
            0: return 1'b0;
            1: return 1'b1;
            2: return logic'(k % 2);
            default: return logic'((k / 4) % 2);
        endcase
    endfunction

    int ts = T_RTI;
    logic [TGT-1:0] br = '0;
    logic [7:0] ir = 8'hFF, irs = 8'h00;
    int capcnt = 0, shcnt = 0, rises = 0, rises_total = 0, cur_len = 1;
    realtime last_rise = 0;

    always @(posedge tck) begin
        if (rises < 5) chk(tms == 1'b1, "R3 tms during reset walk", tms, 1);
        if (rises > 0 && rises < 40)
            chk(($realtime - last_rise) == 2.0 * CLK_PERIOD, "R2 tck period",
                int'($realtime - last_rise), 2 * CLK_PERIOD);
        last_rise = $realtime;
        rises++;
        rises_total++;
        case (ts)
            T_TLR: ir <= 8'hFF;
            T_CDR: begin
                chk(ir == CODE, "R3 capture under sample code", ir, CODE);
                for (int i = 0; i < TGT; i++) br[i] <= pinv(i, capcnt);
                capcnt++;
                shcnt = 0;
            end
            T_SHD: begin
                br <= {tdi, br[TGT-1:1]};
                shcnt++;
            end
            T_UDR: chk(shcnt == cur_len, "R4 shift clocks per snapshot", shcnt, cur_len);
            T_CIR: irs <= 8'h01;
            T_SHI: irs <= {tdi, irs[7:1]};
            T_UIR: begin
                ir <= irs;
                chk(irs == CODE, "R3 instruction code", irs, CODE);
            end
            default: ;
        endcase
        ts <= nxt(ts, tms);
    end

    always @(negedge tck) tdo <= (ts == T_SHD) ? br[0] : 1'b0;

    // ---------------- expected status ----------------
    function automatic int expst(int i, int base, int s, int w);
        int t = 0;
        int ww = (w <= 0) ? 1 : w;
        for (int j = (s / ww) * ww; j <= s; j++)
            if (j >= 1 && pinv(i, base + j) != pinv(i, base + j - 1)) t = 1;
        return t ? 2 : int'(pinv(i, base + s));
    endfunction

    task automatic wait_ready();
        do @(negedge clk); while (!snap_ready);
    endtask

    task automatic run_cfg(int len, int w, int nsnap);
        int base;
        int extra;
        int r0;
        logic [1:0] hold;
        @(negedge clk);
        chain_len = LW'(len);
        win_len = WW'(w);
        cur_len = len;
        rises = 0;
        base = capcnt;
        run = 1'b1;
        repeat (4) @(negedge clk);
        rd_addr = '0;
        #1 chk(rd_stat == 2'b11, "R6 no snapshot yet", rd_stat, 3);
        for (int s = 0; s < nsnap; s++) begin
            wait_ready();
            #1 chk(snap_ready == 1'b1, "R5 ready seen", snap_ready, 1);
            for (int i = 0; i < len; i++) begin
                rd_addr = LW'(i);
                #1 chk(int'(rd_stat) == expst(i, base, s, w),
                       (s == 0) ? "R8 first snapshot" : ((len >= 400) ? "R10 long chain" : "R7 window class"),
                       rd_stat, expst(i, base, s, w));
            end
            @(negedge clk);
            chk(snap_ready == 1'b0, "R5 ready one cycle", snap_ready, 0);
        end
        run = 1'b0;
        extra = 0;
        repeat (2 * len + 80) begin
            @(negedge clk);
            if (snap_ready) extra++;
        end
        chk(extra <= 1, "R9 snapshots after stop", extra, 1);
        rd_addr = '0;
        #1 hold = rd_stat;
        r0 = rises_total;
        repeat (200) @(negedge clk);
        chk(rises_total == r0 && tck == 1'b0, "R9 tck idle after stop", rises_total - r0, 0);
        #1 chk(rd_stat == hold, "R9 status held after stop", rd_stat, hold);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(tck == 1'b0, "R1 tck in reset", tck, 0);
        chk(tms == 1'b1, "R1 tms in reset", tms, 1);
        chk(snap_ready == 1'b0, "R1 ready in reset", snap_ready, 0);
        #1 chk(rd_stat == 2'b11, "R1 status in reset", rd_stat, 3);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(tck == 1'b0 && tms == 1'b1, "R1 idle after reset", {tck, tms}, 1);
        run_cfg(TGT, 2, 3);
        run_cfg(1, 1, 5);
        run_cfg(13, 3, 9);
        run_cfg(7, 4, 10);
        run_cfg(9, 0, 6);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errs++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule